// File: doc/BRIEF.md
# Prescaled CPU-Cycle Interrupt Timer

This block raises a timed interrupt request toward a CPU. An 8-bit up-counter advances once for every 114 CPU cycles. When it steps past 0xFF, it raises the interrupt and reloads itself from an 8-bit latch. Software programs the latch one nibble at a time. It starts, stops or re-arms the counter through a control register, and it clears the request through an acknowledge register. The host bus supplies each write as a single-cycle strobe with an address and data. The CPU-cycle rate arrives as a clock enable, one pulse per CPU cycle.

The interrupt output is a level. Once raised, it stays high until software writes either the control register or the acknowledge register. A control bit, called keep-running, sets what happens after the counter fires. With keep-running clear, counting stops. With it set, counting carries on at the same period. Writing the acknowledge register copies keep-running into the run bit, so the same write both clears the request and, if keep-running is set, restarts counting.

Top module: `cyc_irq_timer`

## Requirements
- R1: After reset the latch, counter, prescaler, both control bits and the interrupt output are zero, and no interrupt appears while no register is written, however many CPU cycles pass.
- R2: A write whose address ANDed with 0xF00C equals 0xF000 loads wr_data[3:0] into latch bits 3:0. One whose masked address equals 0xF004 loads wr_data[3:0] into latch bits 7:4. Address bits 0, 1 and 4..11 and data bits 7:4 are ignored.
- R3: A write at masked address 0xF008 stores wr_data[1:0] as the control bits (bit 1 = run, bit 0 = keep-running) and clears the interrupt. When bit 1 is set, it also loads the counter from the latch and zeroes the prescaler. No counting step is taken in the cycle of this write.
- R4: A write at masked address 0xF00C sets both control bits to the value of keep-running and clears the interrupt. Counting in that cycle uses the updated run bit.
- R5: The prescaler advances only in cycles with cpu_ce high and the run bit set. It holds otherwise. It wraps after 114 counted cycles and keeps its phase across counter events.
- R6: A prescaler wrap with the counter at 0xFF raises the interrupt and reloads the counter from the latch, including any latch nibble written in that same cycle. Any other wrap increments the counter. From a load of latch value L, the interrupt rises on CPU cycle 114*(256-L).
- R7: When the counter fires, both control bits take the value of keep-running. With keep-running clear, counting stops. With it set, the next interrupt follows after another 114*(256-L) CPU cycles.
- R8: The interrupt output stays high until a control or acknowledge write.
- R9: When an acknowledge write and a firing wrap fall in the same cycle, the interrupt output is high after that cycle.
- R10: Writes whose masked address is none of the four register addresses (for example 0xE008, 0x8000, 0xA000) change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_ce | input | 1 | One-cycle enable per CPU cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 16 | Write address |
| wr_data | input | 8 | Write data |
| irq | output | 1 | Level interrupt request |

## Verification
Two pairs of events can land on the same clock edge. In the first, an acknowledge write coincides with the wrap that fires the counter. The bench runs 113 enabled cycles from a 0xFF load and then drives the acknowledge write together with the 114th enable. The interrupt must read high afterwards, because the firing wins over the clear. In the second, a latch nibble write coincides with the firing wrap. Provoked the same way, the reload must use the new latch value, which the bench judges from the length of the following period: 228 cycles rather than 114.

// File: rtl/cit_pkg.sv
package cit_pkg;

  // Register slot order inside the decoded window (slot * 4 = address offset)
  localparam int unsigned SLOT_LAT_LO = 0;
  localparam int unsigned SLOT_LAT_HI = 1;
  localparam int unsigned SLOT_CTRL   = 2;
  localparam int unsigned SLOT_ACK    = 3;
  localparam int unsigned NUM_SLOTS   = 4;

  // Control bit positions
  localparam int unsigned CB_KEEP = 0;
  localparam int unsigned CB_RUN  = 1;

  typedef logic [1:0] ctrl_t;

  typedef struct packed {
    logic ack;
    logic ctl;
    logic lat_hi;
    logic lat_lo;
  } wr_strb_t;

  // Both control bits take the keep-running value
  function automatic ctrl_t ctrl_fold(input ctrl_t c);
    return {c[CB_KEEP], c[CB_KEEP]};
  endfunction

endpackage

// File: rtl/cit_decode.sv
module cit_decode
  import cit_pkg::*;
#(
  parameter int unsigned          ADDR_W    = 16,
  parameter logic [ADDR_W-1:0]    ADDR_MASK = 16'hF00C,
  parameter logic [ADDR_W-1:0]    ADDR_BASE = 16'hF000,
  parameter int unsigned          SLOT_STEP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output wr_strb_t          strb
);

  logic [NUM_SLOTS-1:0] hit;
  logic [ADDR_W-1:0]    masked;

  assign masked = wr_addr & ADDR_MASK;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    localparam logic [ADDR_W-1:0] SLOT_ADDR = ADDR_BASE + ADDR_W'(s * SLOT_STEP);
    assign hit[s] = wr_en && (masked == SLOT_ADDR);
  end

  assign strb.lat_lo = hit[SLOT_LAT_LO];
  assign strb.lat_hi = hit[SLOT_LAT_HI];
  assign strb.ctl    = hit[SLOT_CTRL];
  assign strb.ack    = hit[SLOT_ACK];

  // R10: at most one register is selected by any write
  p_one_slot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.ack, strb.ctl, strb.lat_hi, strb.lat_lo}));

endmodule

// File: rtl/cit_prescaler.sv
module cit_prescaler #(
  parameter int unsigned DIV   = 114,
  localparam int unsigned PRE_W = $clog2(DIV)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  output logic tick
);

  localparam logic [PRE_W-1:0] LAST = PRE_W'(DIV - 1);

  logic [PRE_W-1:0] phase;

  function automatic logic [PRE_W-1:0] phase_next(input logic [PRE_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign tick = step && !clr && (phase == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     phase <= '0;
    else if (clr)   phase <= '0;
    else if (step)  phase <= phase_next(phase);
  end

  // R5: phase never leaves its range
  p_phase_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= LAST);

  // R5: no enabled cycle means the phase holds
  p_phase_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !step) |=> $stable(phase));

  // R5: a wrap restarts the phase at zero
  p_phase_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (phase == '0));

endmodule

// File: rtl/cit_core.sv
module cit_core
  import cit_pkg::*;
#(
  parameter int unsigned NIB_W = 4,
  localparam int unsigned CNT_W = 2 * NIB_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wr_strb_t         strb,
  input  logic [NIB_W-1:0] wdat,
  input  logic             ptick,
  output logic             run_en,
  output logic             presc_clr,
  output logic             fire,
  output logic             irq
);

  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] latch, latch_nx;
  logic [CNT_W-1:0] count, count_nx;
  ctrl_t            ctrl, ctrl_eff, ctrl_nx;
  logic             irq_nx;
  logic             clr_req;

  function automatic logic [CNT_W-1:0] put_nib(input logic [CNT_W-1:0] old,
                                              input logic [NIB_W-1:0] nib,
                                              input logic             upper);
    logic [CNT_W-1:0] r;
    r = old;
    if (upper) r[CNT_W-1:NIB_W] = nib;
    else       r[NIB_W-1:0]     = nib;
    return r;
  endfunction

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] c);
    return c + 1'b1;
  endfunction

  // Latch as it stands after this cycle's nibble writes
  always_comb begin
    latch_nx = latch;
    if (strb.lat_lo) latch_nx = put_nib(latch_nx, wdat, 1'b0);
    if (strb.lat_hi) latch_nx = put_nib(latch_nx, wdat, 1'b1);
  end

  // Control as it stands after this cycle's register write
  always_comb begin
    if (strb.ctl)      ctrl_eff = wdat[1:0];
    else if (strb.ack) ctrl_eff = ctrl_fold(ctrl);
    else               ctrl_eff = ctrl;
  end

  assign clr_req   = strb.ctl || strb.ack;
  assign presc_clr = strb.ctl && wdat[CB_RUN];
  assign run_en    = ctrl_eff[CB_RUN] && !strb.ctl;
  assign fire      = ptick && (count == TOP);

  always_comb begin
    count_nx = count;
    ctrl_nx  = ctrl_eff;
    irq_nx   = irq;
    if (presc_clr) begin
      count_nx = latch;
    end else if (fire) begin
      count_nx = latch_nx;
      ctrl_nx  = ctrl_fold(ctrl_eff);
    end else if (ptick) begin
      count_nx = bump(count);
    end
    if (fire)         irq_nx = 1'b1;
    else if (clr_req) irq_nx = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch <= '0;
      count <= '0;
      ctrl  <= '0;
      irq   <= 1'b0;
    end else begin
      latch <= latch_nx;
      count <= count_nx;
      ctrl  <= ctrl_nx;
      irq   <= irq_nx;
    end
  end

  // R6: a firing wrap raises the request
  p_fire_raises_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> irq);

  // R6: reload takes the latch including same-cycle nibble writes
  p_fire_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (count == $past(latch_nx)));

  // R3: run-bit control write loads the counter from the latch
  p_ctl_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.ctl && wdat[CB_RUN]) |=> (count == $past(latch)));

  // R7: firing with keep-running clear leaves counting stopped
  p_fire_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !ctrl_eff[CB_KEEP]) |=> (ctrl == 2'b00));

  // R8: request holds while nothing clears it
  p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_req) |=> irq);

  // R4: clearing write without a firing wrap drops the request
  p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !fire) |=> !irq);

  // R9: firing wrap wins over a same-cycle acknowledge
  p_fire_over_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.ack && fire) |=> irq);

endmodule

// File: rtl/cyc_irq_timer.sv
module cyc_irq_timer
  import cit_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 16,
  parameter int unsigned       DATA_W    = 8,
  parameter int unsigned       NIB_W     = 4,
  parameter int unsigned       DIV       = 114,
  parameter logic [ADDR_W-1:0] ADDR_MASK = 16'hF00C,
  parameter logic [ADDR_W-1:0] ADDR_BASE = 16'hF000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_ce,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              irq
);

  wr_strb_t strb;
  logic     run_en;
  logic     presc_clr;
  logic     presc_step;
  logic     ptick;
  logic     fire;
  logic     unused_data_hi;

  assign unused_data_hi = ^wr_data[DATA_W-1:NIB_W];

  cit_decode #(
    .ADDR_W    (ADDR_W),
    .ADDR_MASK (ADDR_MASK),
    .ADDR_BASE (ADDR_BASE),
    .SLOT_STEP (4)
  ) u_decode (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .strb    (strb)
  );

  assign presc_step = cpu_ce && run_en;

  cit_prescaler #(
    .DIV (DIV)
  ) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (presc_clr),
    .step  (presc_step),
    .tick  (ptick)
  );

  cit_core #(
    .NIB_W (NIB_W)
  ) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .wdat      (wr_data[NIB_W-1:0]),
    .ptick     (ptick),
    .run_en    (run_en),
    .presc_clr (presc_clr),
    .fire      (fire),
    .irq       (irq)
  );

  // R5: a prescaler wrap only comes from an enabled CPU cycle
  p_tick_needs_ce_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ptick |-> (cpu_ce && run_en));

  // R6: firing always coincides with a prescaler wrap
  p_fire_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> ptick);

endmodule

// File: tb/sim_cyc_irq_timer.sv
`timescale 1ns/1ps
module sim_cyc_irq_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_ce = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cyc_irq_timer u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .cpu_ce  (cpu_ce),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .irq     (irq)
  );

  // {latch, control data, expected CPU cycles to interrupt}
  localparam logic [31:0] VEC [5] = '{
    32'hFF03_0072,
    32'hFE02_00E4,
    32'hFD03_0156,
    32'hF003_0720,
    32'h0003_7200
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic ce_v);
    wr_en = 1'b1; wr_addr = a; wr_data = d; cpu_ce = ce_v;
    @(negedge clk);
    wr_en = 1'b0; cpu_ce = 1'b0;
  endtask

  task automatic idle(input int n, input logic ce_v);
    for (int k = 0; k < n; k++) begin
      cpu_ce = ce_v;
      @(negedge clk);
    end
    cpu_ce = 1'b0;
  endtask

  task automatic run_until(input int max_n, output int n);
    n = 0;
    while (!irq && n < max_n) begin
      cpu_ce = 1'b1;
      @(negedge clk);
      n++;
    end
    cpu_ce = 1'b0;
  endtask

  task automatic load(input logic [7:0] l, input logic [7:0] mode);
    wr(16'hF000, {4'h0, l[3:0]}, 1'b0);
    wr(16'hF004, {4'h0, l[7:4]}, 1'b0);
    wr(16'hF008, mode, 1'b0);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk(irq == 1'b0, "R1 irq low in reset", irq, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(irq == 1'b0, "R1 irq low after reset", irq, 0);
    idle(300, 1'b1);
    chk(irq == 1'b0, "R1 idle counting off", irq, 0);

    // vector table: period, then re-arm or stop behaviour
    for (int i = 0; i < 5; i++) begin
      logic [7:0] l, m;
      int exp;
      l = VEC[i][31:24]; m = VEC[i][23:16]; exp = int'(VEC[i][15:0]);
      load(l, m);
      run_until(40000, n);
      chk(n == exp, "R6 period from load", n, exp);
      if (m[0]) begin
        wr(16'hF00C, 8'h00, 1'b0);
        chk(irq == 1'b0, "R4 ack clears", irq, 0);
        run_until(40000, n);
        chk(n == exp, "R7 keep-running next period", n, exp);
        wr(16'hF008, 8'h00, 1'b0);
      end else begin
        idle(300, 1'b1);
        chk(irq == 1'b1, "R8 level holds", irq, 1);
        wr(16'hF00C, 8'h00, 1'b0);
        idle(400, 1'b1);
        chk(irq == 1'b0, "R7 counting stopped", irq, 0);
      end
    end

    // R10: out-of-window writes change nothing
    load(8'hFF, 8'h03);
    wr(16'hE008, 8'h00, 1'b0);
    wr(16'h8000, 8'h00, 1'b0);
    wr(16'hA000, 8'h0F, 1'b0);
    wr(16'hE00C, 8'h00, 1'b0);
    run_until(40000, n);
    chk(n == 114, "R10 foreign writes ignored", n, 114);
    wr(16'hF008, 8'h00, 1'b0);

    // R2: aliased addresses and ignored data bits
    wr(16'hF003, 8'hAD, 1'b0);
    wr(16'hF006, 8'h5F, 1'b0);
    wr(16'hF008, 8'h02, 1'b0);
    run_until(40000, n);
    chk(n == 342, "R2 latch via aliases", n, 342);

    // R5: no counting without cpu_ce
    load(8'hFF, 8'h03);
    idle(500, 1'b0);
    chk(irq == 1'b0, "R5 no ce no count", irq, 0);
    run_until(40000, n);
    chk(n == 114, "R5 period in ce pulses", n, 114);

    // R3/R4: stop via control, resume via ack keeps prescaler phase
    load(8'hFF, 8'h03);
    idle(50, 1'b1);
    wr(16'hF008, 8'h01, 1'b0);
    idle(200, 1'b1);
    chk(irq == 1'b0, "R3 run bit clear stops", irq, 0);
    wr(16'hF00C, 8'h00, 1'b0);
    run_until(40000, n);
    chk(n == 64, "R4 ack resumes held phase", n, 64);

    // R3: mid-count control write restarts counter and prescaler
    load(8'hFF, 8'h03);
    idle(70, 1'b1);
    wr(16'hF008, 8'h02, 1'b0);
    run_until(40000, n);
    chk(n == 114, "R3 reload clears prescaler", n, 114);

    // R9: ack in the firing cycle
    load(8'hFF, 8'h03);
    idle(113, 1'b1);
    chk(irq == 1'b0, "R9 not yet fired", irq, 0);
    wr(16'hF00C, 8'h00, 1'b1);
    chk(irq == 1'b1, "R9 fire wins over ack", irq, 1);
    wr(16'hF00C, 8'h00, 1'b0);
    chk(irq == 1'b0, "R4 plain ack clears", irq, 0);

    // R6: latch nibble write in the firing cycle feeds the reload
    idle(113, 1'b1);
    wr(16'hF000, 8'h0E, 1'b1);
    chk(irq == 1'b1, "R6 fired with latch write", irq, 1);
    wr(16'hF00C, 8'h00, 1'b0);
    run_until(40000, n);
    chk(n == 228, "R6 reload uses new latch", n, 228);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int c = 0; c < 190000; c++) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule